// File: doc/BRIEF.md
# Prescaled Interval Timer with Watchdog Lock

This block is a single-channel interval timer reached through a small word-wide register port. An input clock is first divided by a 16-bit prescaler. The divided ticks then advance a 16-bit period counter. When a period completes, the block either emits an interrupt pulse or, once watchdog operation has been armed, emits a one-cycle reset pulse. The timer can stop after one period or restart automatically.

The block also owns one IO pin. The pin can sit idle, or serve as an edge source that stamps the running period count into a capture register. It can also act as a general-purpose line, driven push-pull or open-collector. Software programs the period and prescaler together in one packed word. Watchdog operation cannot be turned off by software: once it is armed, only a system reset releases it.

Register map (word address on `bus_addr`): 0 = control, 1 = count, 2 = service on write and capture on read, 3 = pin configuration. Reads are combinational from `bus_addr`.

Top module: `ptw_top`

## Requirements
- R1: After reset, `irq`, `wdt_rst` and `pin_oe` are 0, and both the control and count registers read 0.
- R2: The count register holds the prescaler in bits 31:16 and the period in bits 15:0. Control bit 2 starts the counter, and bit 4 enables interrupts. If control is written with bit 2 set while the counter is idle, `irq` is high for exactly the single cycle that follows `prescaler × period` clock edges after that write. With control bit 3 clear (one-shot), control bit 2 then reads back 0.
- R3: A prescaler field of 0 divides by 65536, and a period field of 0 counts 65536 ticks.
- R4: With control bit 3 set (continuous), the counter reloads, and `irq` pulses again every `prescaler × period` clocks.
- R5: With control bit 4 clear, a period expiry produces no `irq`, and the one-shot counter still stops.
- R6: Writing the count register while the counter runs restarts the prescaler and counter at that write edge. The next expiry falls `new prescaler × new period` clocks later, and the old expiry point passes silently.
- R7: Control bit 5 arms the watchdog. While armed, bits 5 and 2 read 1 and bit 4 reads 0. Writes that try to clear bit 5 or bit 2 have no effect until reset.
- R8: While armed, writing 0x0000A5C3 to address 2 restarts the period, and any other value is ignored. An unserviced expiry pulses `wdt_rst` for one cycle and never raises `irq`.
- R9: Control bits 1:0 select the pin function: 0 idle, 1 capture, 2 general-purpose. In capture mode `pin_oe` is 0. The edge chosen by control bits 7:6 (1 rising, 2 falling) is detected after a two-stage synchronizer. It latches the current period count into capture bits 15:0 and, with bit 4 set, pulses `irq`. The other edge does neither.
- R10: Pin configuration bit 0 selects open-collector, bit 1 is the output value and bit 2 enables output; bit 8 reads the synchronized pin level. In general-purpose push-pull mode, `pin_oe` equals bit 2 and `pin_out` equals bit 1. With pin mode 0, `pin_oe` is 0.
- R11: In open-collector mode, `pin_out` is 0 and `pin_oe` is high only when output is enabled and the value is 0. Control writes leave the pin configuration register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer and register clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | One-cycle interrupt pulse |
| wdt_rst | output | 1 | One-cycle watchdog reset pulse |
| pin_in | input | 1 | Pin level from the pad |
| pin_out | output | 1 | Pin drive value |
| pin_oe | output | 1 | Pin drive enable |

## Verification
The bench targets the one-based division arithmetic, where an off-by-one would move the interrupt one prescaler step early or late. It also exercises the zero encodings: a design that treats zero literally would fire at once or never. A count write in mid-period must move the expiry. A design that kept its old progress would fire at the stale point, which the bench watches for.

Watchdog tests attempt to disarm and stop the counter, and they send a wrong service key. A leaky lock would let interrupts through or drop the reset pulse. A loose key compare would postpone the pulse. Pin tests check capture on only the chosen edge at the synchronizer's latency. They also check that open-collector never drives high and that the pin configuration survives control writes.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int REG_AW = 2;

    typedef enum logic [1:0] {
        PM_OFF  = 2'd0,
        PM_CAPT = 2'd1,
        PM_GPIO = 2'd2,
        PM_RSVD = 2'd3
    } pin_mode_e;

    localparam logic [1:0] EDGE_RISE = 2'd1;
    localparam logic [1:0] EDGE_FALL = 2'd2;

    localparam logic [REG_AW-1:0] A_CTRL  = 2'd0;
    localparam logic [REG_AW-1:0] A_COUNT = 2'd1;
    localparam logic [REG_AW-1:0] A_SVC   = 2'd2;
    localparam logic [REG_AW-1:0] A_PIN   = 2'd3;

    // control word, LSB first: msel[1:0], en[2], cont[3], ie[4], wde[5], edge_sel[7:6]
    typedef struct packed {
        logic [1:0] edge_sel;
        logic       wde;
        logic       ie;
        logic       cont;
        logic       en;
        pin_mode_e  msel;
    } ctrl_t;

    // pin word, LSB first: od[0], val[1], dir[2]
    typedef struct packed {
        logic dir;
        logic val;
        logic od;
    } pincfg_t;

endpackage

// File: rtl/ptw_count.sv
module ptw_count #(
    parameter int PSC_W = 16,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [PSC_W-1:0] psc,
    input  logic [CNT_W-1:0] per,
    output logic             expire,
    output logic [CNT_W-1:0] cnt_val
);

    localparam logic [PSC_W-1:0] PSC_ONE = PSC_W'(1);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [PSC_W-1:0] pre;
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    pre_last, cnt_last;

    always_comb begin
        st_d     = st_q;
        expire   = 1'b0;
        // one-based terminal value: a field of 0 wraps to all ones, i.e. 2**W steps
        pre_last = (st_q.pre == (psc - PSC_ONE));
        cnt_last = (st_q.cnt == (per - CNT_ONE));
        if (restart) begin
            st_d = '0;
        end else if (run) begin
            if (pre_last) begin
                st_d.pre = '0;
                if (cnt_last) begin
                    st_d.cnt = '0;
                    expire   = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + CNT_ONE;
                end
            end else begin
                st_d.pre = st_q.pre + PSC_ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_val = st_q.cnt;

endmodule

// File: rtl/ptw_pin.sv
module ptw_pin
    import ptw_pkg::*;
#(
    parameter int SYNC_N = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_in,
    input  pin_mode_e  mode,
    input  logic [1:0] edge_sel,
    input  pincfg_t    cfg,
    output logic       pin_out,
    output logic       pin_oe,
    output logic       edge_evt,
    output logic       pin_lvl
);

    typedef struct packed {
        logic [SYNC_N-1:0] sync;
        logic              prev;
    } pin_st_t;

    pin_st_t st_d, st_q;
    logic    rise, fall;

    always_comb begin
        st_d.sync = {st_q.sync[SYNC_N-2:0], pin_in};
        st_d.prev = st_q.sync[SYNC_N-1];
        pin_lvl   = st_q.sync[SYNC_N-1];
        rise      = pin_lvl & ~st_q.prev;
        fall      = ~pin_lvl & st_q.prev;
        edge_evt  = 1'b0;
        if (mode == PM_CAPT) begin
            case (edge_sel)
                EDGE_RISE: edge_evt = rise;
                EDGE_FALL: edge_evt = fall;
                default:   edge_evt = 1'b0;
            endcase
        end
    end

    always_comb begin
        pin_out = 1'b0;
        pin_oe  = 1'b0;
        if (mode == PM_GPIO) begin
            if (cfg.od) begin
                pin_out = 1'b0;
                pin_oe  = cfg.dir & ~cfg.val;
            end else begin
                pin_out = cfg.val;
                pin_oe  = cfg.dir;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/ptw_regs.sv
module ptw_regs
    import ptw_pkg::*;
#(
    parameter int              DATA_W  = 32,
    parameter int              PSC_W   = 16,
    parameter int              CNT_W   = 16,
    parameter logic [15:0]     SVC_KEY = 16'hA5C3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              expire,
    input  logic              edge_evt,
    input  logic              pin_lvl,
    input  logic [CNT_W-1:0]  cnt_val,
    output ctrl_t             ctrl,
    output pincfg_t           pincfg,
    output logic [PSC_W-1:0]  psc,
    output logic [CNT_W-1:0]  per,
    output logic              restart,
    output logic              irq,
    output logic              wdt_rst
);

    localparam int CTRL_W = $bits(ctrl_t);
    localparam int PIN_W  = $bits(pincfg_t);
    localparam int LVL_B  = 8;
    localparam logic [DATA_W-1:0] KEY_WORD = DATA_W'(SVC_KEY);

    typedef struct packed {
        ctrl_t            ctrl;
        pincfg_t          pin;
        logic [PSC_W-1:0] psc;
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] cap;
        logic             irq;
        logic             rst_pulse;
    } reg_st_t;

    reg_st_t st_d, st_q;
    ctrl_t   wctl;

    always_comb begin
        st_d    = st_q;
        restart = 1'b0;
        wctl    = ctrl_t'(wdata[CTRL_W-1:0]);

        // one-shot completion stops the counter unless the watchdog holds it
        if (expire && !st_q.ctrl.cont && !st_q.ctrl.wde)
            st_d.ctrl.en = 1'b0;

        if (edge_evt)
            st_d.cap = cnt_val;

        if (wr_en) begin
            case (addr)
                A_CTRL: begin
                    if (st_q.ctrl.wde) wctl.wde = 1'b1;
                    if (wctl.wde) begin
                        wctl.en = 1'b1;
                        wctl.ie = 1'b0;
                    end
                    if (wctl.en && !st_q.ctrl.en) restart = 1'b1;
                    st_d.ctrl = wctl;
                end
                A_COUNT: begin
                    st_d.psc = wdata[PSC_W+CNT_W-1:CNT_W];
                    st_d.per = wdata[CNT_W-1:0];
                    if (st_q.ctrl.en) restart = 1'b1;
                end
                A_SVC: begin
                    if (st_q.ctrl.wde && (wdata == KEY_WORD)) restart = 1'b1;
                end
                A_PIN: begin
                    st_d.pin = pincfg_t'(wdata[PIN_W-1:0]);
                end
                default: ;
            endcase
        end

        st_d.irq       = st_q.ctrl.ie & (expire | edge_evt);
        st_d.rst_pulse = st_q.ctrl.wde & expire;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL:  rdata = DATA_W'(st_q.ctrl);
            A_COUNT: rdata = DATA_W'({st_q.psc, st_q.per});
            A_SVC:   rdata = DATA_W'(st_q.cap);
            default: begin
                rdata[PIN_W-1:0] = st_q.pin;
                rdata[LVL_B]     = pin_lvl;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl    = st_q.ctrl;
    assign pincfg  = st_q.pin;
    assign psc     = st_q.psc;
    assign per     = st_q.per;
    assign irq     = st_q.irq;
    assign wdt_rst = st_q.rst_pulse;

endmodule

// File: rtl/ptw_top.sv
module ptw_top
    import ptw_pkg::*;
#(
    parameter int          DATA_W  = 32,
    parameter int          PSC_W   = 16,
    parameter int          CNT_W   = 16,
    parameter int          SYNC_N  = 2,
    parameter logic [15:0] SVC_KEY = 16'hA5C3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              wdt_rst,
    input  logic              pin_in,
    output logic              pin_out,
    output logic              pin_oe
);

    ctrl_t            ctrl;
    pincfg_t          pincfg;
    logic [PSC_W-1:0] psc;
    logic [CNT_W-1:0] per;
    logic [CNT_W-1:0] cnt_val;
    logic             restart, expire, edge_evt, pin_lvl;

    // named views for the bound checker
    logic      wd_on, en_on, ie_on, od_on;
    pin_mode_e msel;
    assign wd_on = ctrl.wde;
    assign en_on = ctrl.en;
    assign ie_on = ctrl.ie;
    assign od_on = pincfg.od;
    assign msel  = ctrl.msel;

    ptw_regs #(
        .DATA_W (DATA_W),
        .PSC_W  (PSC_W),
        .CNT_W  (CNT_W),
        .SVC_KEY(SVC_KEY)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .rdata   (bus_rdata),
        .expire  (expire),
        .edge_evt(edge_evt),
        .pin_lvl (pin_lvl),
        .cnt_val (cnt_val),
        .ctrl    (ctrl),
        .pincfg  (pincfg),
        .psc     (psc),
        .per     (per),
        .restart (restart),
        .irq     (irq),
        .wdt_rst (wdt_rst)
    );

    ptw_count #(
        .PSC_W(PSC_W),
        .CNT_W(CNT_W)
    ) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (ctrl.en),
        .restart(restart),
        .psc    (psc),
        .per    (per),
        .expire (expire),
        .cnt_val(cnt_val)
    );

    ptw_pin #(
        .SYNC_N(SYNC_N)
    ) u_pin (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_in  (pin_in),
        .mode    (ctrl.msel),
        .edge_sel(ctrl.edge_sel),
        .cfg     (pincfg),
        .pin_out (pin_out),
        .pin_oe  (pin_oe),
        .edge_evt(edge_evt),
        .pin_lvl (pin_lvl)
    );

endmodule

// File: rtl/ptw_top_chk.sv
module ptw_top_chk
    import ptw_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      irq,
    input logic      wdt_rst,
    input logic      pin_out,
    input logic      pin_oe,
    input logic      wd_on,
    input logic      en_on,
    input logic      ie_on,
    input logic      od_on,
    input pin_mode_e msel
);

    p_wd_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wd_on |=> wd_on);

    p_wd_keeps_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wd_on |=> en_on);

    p_wd_masks_ie_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wd_on |-> !ie_on);

    p_no_irq_armed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !$past(wd_on));

    p_rst_only_armed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst |-> $past(wd_on));

    p_capture_undriven_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (msel == PM_CAPT) |-> !pin_oe);

    p_idle_undriven_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (msel == PM_OFF) |-> !pin_oe);

    p_oc_never_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((msel == PM_GPIO) && od_on) |-> !pin_out);

endmodule

bind ptw_top ptw_top_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .irq    (irq),
    .wdt_rst(wdt_rst),
    .pin_out(pin_out),
    .pin_oe (pin_oe),
    .wd_on  (wd_on),
    .en_on  (en_on),
    .ie_on  (ie_on),
    .od_on  (od_on),
    .msel   (msel)
);

// File: tb/ptw_top_test.sv
module ptw_top_test;

    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, wdt_rst, pin_in, pin_out, pin_oe;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptw_top uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .irq      (irq),
        .wdt_rst  (wdt_rst),
        .pin_in   (pin_in),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n  = 1'b0;
        bus_wr = 1'b0;
        pin_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // called at a negedge; the write lands on the next posedge
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        check("R1 irq", {31'b0, irq}, 32'd0);
        check("R1 wdt_rst", {31'b0, wdt_rst}, 32'd0);
        check("R1 pin_oe", {31'b0, pin_oe}, 32'd0);
        rd(2'd0, v); check("R1 ctrl", v, 32'd0);
        rd(2'd1, v); check("R1 count", v, 32'd0);
    endtask

    task automatic t_oneshot();
        logic [31:0] v;
        do_reset();
        wr(2'd1, {16'd3, 16'd4});
        rd(2'd1, v); check("R2 count packing", v, 32'h0003_0004);
        wr(2'd0, 32'h14);
        repeat (11) @(negedge clk);
        check("R2 no irq before 12", {31'b0, irq}, 32'd0);
        @(negedge clk);
        check("R2 irq at 12", {31'b0, irq}, 32'd1);
        @(negedge clk);
        check("R2 irq one cycle", {31'b0, irq}, 32'd0);
        rd(2'd0, v); check("R2 one-shot stopped", {31'b0, v[2]}, 32'd0);
    endtask

    task automatic t_zero_fields();
        do_reset();
        wr(2'd1, 32'h0000_0001);
        wr(2'd0, 32'h14);
        repeat (65535) @(negedge clk);
        check("R3 psc0 not early", {31'b0, irq}, 32'd0);
        @(negedge clk);
        check("R3 psc0 = 65536", {31'b0, irq}, 32'd1);
        wr(2'd1, 32'h0001_0000);
        wr(2'd0, 32'h14);
        repeat (65535) @(negedge clk);
        check("R3 per0 not early", {31'b0, irq}, 32'd0);
        @(negedge clk);
        check("R3 per0 = 65536", {31'b0, irq}, 32'd1);
    endtask

    task automatic t_continuous();
        do_reset();
        wr(2'd1, {16'd2, 16'd3});
        wr(2'd0, 32'h1C);
        for (int k = 1; k <= 18; k++) begin
            @(negedge clk);
            if (k == 5 || k == 11 || k == 17)
                check("R4 quiet before period", {31'b0, irq}, 32'd0);
            if (k == 6 || k == 12 || k == 18)
                check("R4 periodic irq", {31'b0, irq}, 32'd1);
        end
    endtask

    task automatic t_no_ie();
        logic [31:0] v;
        logic        seen = 1'b0;
        do_reset();
        wr(2'd1, {16'd1, 16'd4});
        wr(2'd0, 32'h04);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            seen |= irq;
        end
        check("R5 irq masked", {31'b0, seen}, 32'd0);
        rd(2'd0, v); check("R5 still one-shot stop", {31'b0, v[2]}, 32'd0);
    endtask

    task automatic t_reload();
        logic seen = 1'b0;
        do_reset();
        wr(2'd1, {16'd1, 16'd10});
        wr(2'd0, 32'h14);
        repeat (5) @(negedge clk);
        wr(2'd1, {16'd1, 16'd8});
        for (int k = 0; k < 7; k++) begin
            @(negedge clk);
            seen |= irq;
        end
        check("R6 old expiry suppressed", {31'b0, seen}, 32'd0);
        @(negedge clk);
        check("R6 new period irq", {31'b0, irq}, 32'd1);
    endtask

    task automatic t_watchdog();
        logic [31:0] v;
        logic        seen = 1'b0;
        logic        seen_irq = 1'b0;
        do_reset();
        wr(2'd1, {16'd2, 16'd4});
        wr(2'd0, 32'h30);
        rd(2'd0, v); check("R7 armed forces run, masks ie", v, 32'h24);
        wr(2'd0, 32'h00);
        rd(2'd0, v); check("R7 disarm ignored", v, 32'h24);
        wr(2'd2, 32'h0000_A5C3);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            seen |= wdt_rst;
        end
        wr(2'd2, 32'h0000_1234);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            seen |= wdt_rst;
            seen_irq |= irq;
        end
        check("R8 key restarted period", {31'b0, seen}, 32'd0);
        @(negedge clk);
        check("R8 reset pulse on expiry", {31'b0, wdt_rst}, 32'd1);
        seen_irq |= irq;
        check("R8 no irq while armed", {31'b0, seen_irq}, 32'd0);
        @(negedge clk);
        check("R8 reset pulse one cycle", {31'b0, wdt_rst}, 32'd0);
    endtask

    task automatic t_gpio();
        logic [31:0] v;
        do_reset();
        wr(2'd3, 32'h6);
        wr(2'd0, 32'h2);
        check("R10 push-pull oe", {31'b0, pin_oe}, 32'd1);
        check("R10 push-pull high", {31'b0, pin_out}, 32'd1);
        wr(2'd3, 32'h4);
        check("R10 push-pull low", {31'b0, pin_out}, 32'd0);
        wr(2'd3, 32'h7);
        check("R11 oc release on 1", {31'b0, pin_oe}, 32'd0);
        check("R11 oc out low", {31'b0, pin_out}, 32'd0);
        wr(2'd0, 32'h2);
        rd(2'd3, v); check("R11 pin cfg held", {29'b0, v[2:0]}, 32'h7);
        wr(2'd3, 32'h5);
        check("R11 oc sink on 0", {31'b0, pin_oe}, 32'd1);
        wr(2'd0, 32'h0);
        check("R10 idle mode undriven", {31'b0, pin_oe}, 32'd0);
    endtask

    task automatic t_capture();
        logic [31:0] v;
        logic        seen = 1'b0;
        do_reset();
        wr(2'd1, {16'd1, 16'd1000});
        wr(2'd3, 32'h6);
        wr(2'd0, 32'h5D);
        check("R9 capture undriven", {31'b0, pin_oe}, 32'd0);
        repeat (5) @(negedge clk);
        pin_in = 1'b1;
        repeat (2) @(negedge clk);
        check("R9 sync latency", {31'b0, irq}, 32'd0);
        @(negedge clk);
        check("R9 rising edge irq", {31'b0, irq}, 32'd1);
        rd(2'd2, v); check("R9 captured count", v, 32'd7);
        rd(2'd3, v); check("R9 pin level", {31'b0, v[8]}, 32'd1);
        pin_in = 1'b0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            seen |= irq;
        end
        check("R9 falling ignored", {31'b0, seen}, 32'd0);
        wr(2'd0, 32'h9D);
        pin_in = 1'b1;
        seen = 1'b0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            seen |= irq;
        end
        check("R9 rising ignored", {31'b0, seen}, 32'd0);
        pin_in = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 falling edge irq", {31'b0, irq}, 32'd1);
    endtask

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        pin_in = 1'b0;
        t_reset();
        t_oneshot();
        t_continuous();
        t_no_ie();
        t_reload();
        t_watchdog();
        t_gpio();
        t_capture();
        t_zero_fields();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule